// File: doc/BRIEF.md
# Strobe-Qualified Byte Transfer Across Clock Domains

This block carries single bytes from a slow processor bus clock domain into a faster, unrelated logic clock domain. The processor writes a byte into a data register, then drives a one-bit strobe register low and then high. The strobe level crosses into the logic domain through a two-stage synchronizer. A third logic-domain flop follows it, and an edge detector on that flop turns each low-to-high strobe transition into a one-cycle enable. The enable loads the byte into a capture register and raises a one-cycle valid pulse for the downstream processing.

The logic domain returns an echo of the strobe level that it has acted on. That echo is synchronized back into the processor domain. The processor reads a ready bit that is 1 whenever the echo matches the strobe it last wrote, so software can poll until the byte it posted has been taken. The scheme needs the logic clock to be clearly faster than the processor clock, and it is sized for byte rates of a few million per second.

Top module: `strobe_xfer`

## Requirements
- R1: After both resets, `cap_valid` is 0, `cap_data` is 0, and a read of address 1 returns 1 in bit 0 (ready).
- R2: Register map: a write to address 0 loads the byte register and a write to address 1 loads the strobe from `cpu_wdata` bit 0. A read of address 1 returns ready in bit 0 with all other bits 0. A read of any other address returns 0.
- R3: Each 0-to-1 transition of the strobe register produces exactly one capture, and the captured byte equals the value the byte register held at that transition.
- R4: A write to the byte register alone, a strobe write of 1 while the strobe is already 1, and a strobe write of 0 never produce a capture.
- R5: `cap_valid` is high for exactly one logic clock cycle per capture.
- R6: `cap_data` keeps its value in every cycle in which `cap_valid` is low.
- R7: Ready reads 0 right after a strobe write that changes the strobe level. It reads 1 again once the logic domain has answered that level, and only from then may the byte register or the strobe be written.
- R8: Bytes sent one after another with the ready protocol come out in the order written, each exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Processor bus clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| cpu_we | input | 1 | Register write enable |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational on `cpu_addr`) |
| log_clk | input | 1 | Logic domain clock, faster than `cpu_clk` |
| log_rst | input | 1 | Synchronous active-high reset, logic domain |
| cap_data | output | 8 | Captured byte |
| cap_valid | output | 1 | One-cycle pulse when `cap_data` has been loaded |

## Verification
The assertions assume that software follows the handshake. Neither the byte register nor the strobe is written while ready reads 0, so the byte is stable while the logic domain samples it. The bench driver polls ready before every write of a byte or strobe, so it never leaves that envelope. The bench also runs the logic clock about 1.65 times faster than the processor clock, with periods that share no simple ratio, as the synchronizer depth requires.

// File: rtl/strobe_xfer_pkg.sv
package strobe_xfer_pkg;

    localparam int XFER_DATA_W = 8;
    localparam int XFER_ADDR_W = 2;
    localparam int XFER_SYNC_STAGES = 2;

    typedef enum logic [XFER_ADDR_W-1:0] {
        REG_BYTE = 2'd0,
        REG_CTRL = 2'd1
    } xfer_reg_e;

    typedef struct packed {
        logic                   we;
        logic [XFER_ADDR_W-1:0] addr;
        logic [XFER_DATA_W-1:0] wdata;
    } cpu_wr_t;

    function automatic logic hits(input cpu_wr_t wr, input xfer_reg_e r);
        return wr.we && (wr.addr == r);
    endfunction

endpackage

// File: rtl/xfer_bit_sync.sv
module xfer_bit_sync #(
    parameter int STAGES = strobe_xfer_pkg::XFER_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xfer_cpu_regs.sv
module xfer_cpu_regs
    import strobe_xfer_pkg::*;
#(
    parameter int DATA_W = XFER_DATA_W,
    parameter int ADDR_W = XFER_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              echo_sync,
    output logic [DATA_W-1:0] byte_q,
    output logic              strobe_q,
    output logic [DATA_W-1:0] rdata
);
    cpu_wr_t wr;
    logic    ready;

    assign wr.we    = we;
    assign wr.addr  = addr;
    assign wr.wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            if (hits(wr, REG_BYTE)) byte_q   <= wr.wdata;
            if (hits(wr, REG_CTRL)) strobe_q <= wr.wdata[0];
        end
    end

    // ready while the logic domain has echoed the current strobe level
    assign ready = (echo_sync == strobe_q);

    always_comb begin
        rdata = '0;
        if (addr == REG_CTRL) rdata[0] = ready;
    end

    AST_BYTE_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        hits(wr, REG_BYTE) |-> ready); // R7
    AST_STROBE_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        hits(wr, REG_CTRL) |-> ready); // R7
endmodule

// File: rtl/xfer_capture.sv
module xfer_capture
    import strobe_xfer_pkg::*;
#(
    parameter int DATA_W = XFER_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_sync,
    input  logic [DATA_W-1:0] src_byte,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_valid,
    output logic              echo
);
    logic edge_q;
    logic load_en;

    assign load_en = strobe_sync & ~edge_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q    <= 1'b0;
            cap_data  <= '0;
            cap_valid <= 1'b0;
            echo      <= 1'b0;
        end else begin
            edge_q    <= strobe_sync;
            cap_valid <= load_en;
            echo      <= edge_q;
            if (load_en) cap_data <= src_byte;
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> !cap_valid); // R5
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !cap_valid |-> $stable(cap_data)); // R6
    AST_ECHO_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(echo) |-> $past(cap_valid)); // R3
endmodule

// File: rtl/strobe_xfer.sv
module strobe_xfer
    import strobe_xfer_pkg::*;
#(
    parameter int DATA_W      = XFER_DATA_W,
    parameter int ADDR_W      = XFER_ADDR_W,
    parameter int SYNC_STAGES = XFER_SYNC_STAGES
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              log_clk,
    input  logic              log_rst,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_valid
);
    logic [DATA_W-1:0] byte_q;
    logic              strobe_q;
    logic              strobe_s;
    logic              echo;
    logic              echo_s;

    xfer_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(cpu_clk), .rst(cpu_rst), .we(cpu_we), .addr(cpu_addr),
        .wdata(cpu_wdata), .echo_sync(echo_s), .byte_q(byte_q),
        .strobe_q(strobe_q), .rdata(cpu_rdata)
    );

    xfer_bit_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
        .clk(log_clk), .rst(log_rst), .d(strobe_q), .q(strobe_s)
    );

    xfer_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(log_clk), .rst(log_rst), .strobe_sync(strobe_s),
        .src_byte(byte_q), .cap_data(cap_data), .cap_valid(cap_valid),
        .echo(echo)
    );

    xfer_bit_sync #(.STAGES(SYNC_STAGES)) u_echo_sync (
        .clk(cpu_clk), .rst(cpu_rst), .d(echo), .q(echo_s)
    );
endmodule

// File: tb/strobe_xfer_tb.sv
`timescale 1ns/1ps
module strobe_xfer_tb;
    logic       cpu_clk = 1'b0;
    logic       log_clk = 1'b0;
    logic       cpu_rst = 1'b1;
    logic       log_rst = 1'b1;
    logic       cpu_we = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] cap_data;
    logic       cap_valid;

    int checks = 0;
    int fails = 0;
    int sent = 0;
    int caught = 0;
    logic [7:0] expq[$];
    logic prev_valid = 1'b0;

    always #2.0 log_clk = ~log_clk;
    always #3.3 cpu_clk = ~cpu_clk;

    strobe_xfer u_dut (
        .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .log_clk(log_clk), .log_rst(log_rst),
        .cap_data(cap_data), .cap_valid(cap_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge cpu_clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge cpu_clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic wait_ready();
        logic [7:0] r;
        for (int i = 0; i < 400; i++) begin
            @(negedge cpu_clk);
            cpu_read(2'd1, r);
            if (r[0]) return;
        end
        check(1'b0, "R7", "ready never returned", 0, 1);
    endtask

    task automatic cpu_send(input logic [7:0] b);
        logic [7:0] r;
        wait_ready();
        cpu_write(2'd0, b);
        cpu_write(2'd1, 8'h00);
        wait_ready();
        expq.push_back(b);
        sent++;
        cpu_write(2'd1, 8'h01);
        cpu_read(2'd1, r);
        check(r == 8'h00, "R7", "ready right after strobe rise", r, 0);
        wait_ready();
    endtask

    // scoreboard monitor
    always @(negedge log_clk) begin
        if (!log_rst) begin
            if (cap_valid && prev_valid)
                check(1'b0, "R5", "valid longer than one cycle", 1, 0);
            if (cap_valid) begin
                caught++;
                if (expq.size() == 0) begin
                    check(1'b0, "R3", "capture without strobe rise", cap_data, 0);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    check(cap_data == e, "R8", "captured byte order", cap_data, e);
                end
            end
            prev_valid <= cap_valid;
        end
    end

    initial begin
        repeat (150000) @(posedge log_clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] r;
        int snap;
        logic [7:0] last;
        repeat (10) @(posedge cpu_clk);
        cpu_rst = 1'b0;
        @(posedge log_clk);
        log_rst = 1'b0;
        repeat (8) @(negedge cpu_clk);

        // R1 reset state
        check(cap_valid == 1'b0, "R1", "cap_valid after reset", cap_valid, 0);
        check(cap_data == 8'h00, "R1", "cap_data after reset", cap_data, 0);
        cpu_read(2'd1, r);
        check(r == 8'h01, "R1", "ready after reset", r, 1);
        // R2 map reads
        cpu_read(2'd0, r);
        check(r == 8'h00, "R2", "read of byte address", r, 0);
        cpu_read(2'd2, r);
        check(r == 8'h00, "R2", "read of unused address", r, 0);

        // R3 / R8 distinct patterns
        cpu_send(8'hA5);
        cpu_send(8'h00);
        cpu_send(8'hFF);
        cpu_send(8'h5A);
        for (int i = 0; i < 24; i++) cpu_send(8'(i * 37 + 3));
        last = 8'(23 * 37 + 3);
        repeat (20) @(negedge log_clk);
        check(expq.size() == 0, "R8", "bytes left uncaptured", expq.size(), 0);
        check(caught == sent, "R8", "capture count", caught, sent);

        // R4 writes that must not capture; R6 hold
        snap = caught;
        cpu_write(2'd0, 8'h3C);
        repeat (40) @(negedge log_clk);
        cpu_write(2'd1, 8'h01);
        repeat (40) @(negedge log_clk);
        cpu_read(2'd1, r);
        check(r == 8'h01, "R7", "ready after repeated strobe 1", r, 1);
        cpu_write(2'd1, 8'h00);
        cpu_read(2'd1, r);
        check(r == 8'h00, "R7", "ready right after strobe fall", r, 0);
        wait_ready();
        repeat (40) @(negedge log_clk);
        check(caught == snap, "R4", "captures from non-rising writes", caught, snap);
        check(cap_data == last, "R6", "cap_data held while idle", cap_data, last);

        // R3 strobe rise after data-only write captures that byte
        wait_ready();
        expq.push_back(8'h3C);
        sent++;
        cpu_write(2'd1, 8'h01);
        wait_ready();
        repeat (20) @(negedge log_clk);
        check(caught == snap + 1, "R3", "one capture per rise", caught, snap + 1);
        check(cap_data == 8'h3C, "R3", "byte at strobe rise", cap_data, 8'h3C);
        check(caught == sent, "R8", "final capture count", caught, sent);
        summary();
    end
endmodule